// File: doc/BRIEF.md
# Program-Memory Table Transfer Unit

This block moves single bytes between a byte-addressed program memory and an 8-bit holding latch. It owns a 21-bit table pointer and the latch. A request names a direction (read into the latch, or write the latch out to memory) and one of four pointer-update modes. The unit drives a one-cycle memory strobe with the pointer as address, then applies the mode's pointer update and raises a one-cycle done pulse.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low while a transfer is in flight and while a register-port write is offered. A requester that holds `req_valid` high simply waits. Any valid cycle that meets a low `req_ready` is not taken and leaves no trace. Software sets up the pointer and the latch through a plain register port and can read both at any time.

The memory is synchronous. It sees the strobe and address in one cycle and returns read data in the next cycle. A transfer therefore occupies the unit for two cycles, and `done` follows in the third cycle.

Top module: `tblacc_unit`

## Requirements
- R1: After reset `tbl_ptr` is 0, `tbl_latch` is 0, `busy`, `done`, `mem_rd` and `mem_wr` are low, and `req_ready` is high.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` both high. `busy` is high for the next two cycles. In the third cycle `busy` is low and `done` is high for exactly that one cycle, with pointer and latch already updated. `req_ready` equals `!busy && !cfg_we`.
- R3: A read (`req_write`=0) raises `mem_rd` in the first busy cycle with `mem_addr` equal to the access address. The byte that the memory returns in the following cycle appears in `tbl_latch` when `done` is high.
- R4: A write (`req_write`=1) raises `mem_wr` in the first busy cycle, with `mem_addr` equal to the access address and `mem_wdata` equal to `tbl_latch`. The latch is unchanged.
- R5: Mode 0 (hold) accesses the pointer value and leaves the pointer unchanged.
- R6: Mode 1 (post-increment) accesses the pointer value, then adds 1 to the pointer.
- R7: Mode 2 (post-decrement) accesses the pointer value, then subtracts 1 from the pointer.
- R8: Mode 3 (pre-increment) adds 1 to the pointer on the accepting edge and then accesses the new value. The pointer keeps that value.
- R9: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF + 1 = 0 and 0 - 1 = 0x1FFFFF.
- R10: While busy, `req_valid` and the request fields are ignored. No extra access, pointer change or done pulse results.
- R11: With `cfg_we` high while idle, `cfg_sel`=0 loads `tbl_ptr` from `cfg_wdata` and `cfg_sel`=1 loads `tbl_latch` from `cfg_wdata[7:0]`. Both take effect on the next cycle. A `cfg_we` offered while busy is ignored.
- R12: `mem_rd` and `mem_wr` are never high together, and each lasts exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_write | input | 1 | 1 = write latch to memory, 0 = read memory into latch |
| req_mode | input | 2 | Pointer mode: 0 hold, 1 post-inc, 2 post-dec, 3 pre-inc |
| busy | output | 1 | Transfer in flight |
| done | output | 1 | One-cycle completion pulse |
| cfg_we | input | 1 | Register-port write strobe |
| cfg_sel | input | 1 | 0 = pointer, 1 = latch |
| cfg_wdata | input | 21 | Register-port write data |
| tbl_ptr | output | 21 | Current table pointer |
| tbl_latch | output | 8 | Current latch contents |
| mem_addr | output | 21 | Program-memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |

## Verification
The hardest case to reach from the ports is a request or register write that arrives in the middle of a transfer. The stimulus holds `req_valid` high across both busy cycles and changes direction and mode partway through. It also raises `cfg_we` at the same time, so an unguarded design would start a second access or overwrite the pointer. Wrap-around is reached by loading the pointer to its extreme values through the register port and then stepping it in every mode. A request held valid continuously exercises back-to-back acceptance in the done cycle.

// File: rtl/tblacc_pkg.sv
`timescale 1ns/1ps
package tblacc_pkg;

  typedef enum logic [1:0] {
    PM_HOLD     = 2'd0,
    PM_POST_INC = 2'd1,
    PM_POST_DEC = 2'd2,
    PM_PRE_INC  = 2'd3
  } ptr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FINISH = 2'd2
  } xfer_state_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam logic CFG_SEL_PTR   = 1'b0;
  localparam logic CFG_SEL_LATCH = 1'b1;

endpackage

// File: rtl/tblacc_seq.sv
`timescale 1ns/1ps
module tblacc_seq
  import tblacc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_mode,
  input  logic       cfg_we,
  output logic       req_ready,
  output logic       busy,
  output logic       done,
  output logic       acc_rd,
  output logic       acc_wr,
  output logic       capture,
  output logic       cfg_take,
  output step_e      ptr_step
);

  xfer_state_e state_q, state_d;
  logic        write_q;
  ptr_mode_e   mode_q;
  logic        done_q;
  logic        accept;

  assign req_ready = (state_q == ST_IDLE) && !cfg_we;
  assign accept    = req_valid && req_ready;
  assign cfg_take  = cfg_we && (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign acc_rd    = (state_q == ST_ACCESS) && !write_q;
  assign acc_wr    = (state_q == ST_ACCESS) &&  write_q;
  assign capture   = (state_q == ST_FINISH) && !write_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ptr_step = STEP_NONE;
    if (accept && (ptr_mode_e'(req_mode) == PM_PRE_INC)) begin
      ptr_step = STEP_UP;
    end else if (state_q == ST_FINISH) begin
      if (mode_q == PM_POST_INC)      ptr_step = STEP_UP;
      else if (mode_q == PM_POST_DEC) ptr_step = STEP_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      mode_q  <= PM_HOLD;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FINISH);
      if (accept) begin
        write_q <= req_write;
        mode_q  <= ptr_mode_e'(req_mode);
      end
    end
  end

endmodule

// File: rtl/tblacc_ptr.sv
`timescale 1ns/1ps
module tblacc_ptr
  import tblacc_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  step_e             step,
  output logic [ADDR_W-1:0] ptr_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_en) begin
      ptr_d = load_val;
    end else begin
      unique case (step)
        STEP_UP:   ptr_d = ptr_q + ONE;
        STEP_DOWN: ptr_d = ptr_q - ONE;
        default:   ptr_d = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/tblacc_latch.sv
`timescale 1ns/1ps
module tblacc_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_val,
  output logic [DATA_W-1:0] latch_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (load_en) latch_q <= load_val;
    else if (cap_en)  latch_q <= cap_val;
  end

endmodule

// File: rtl/tblacc_unit.sv
`timescale 1ns/1ps
module tblacc_unit
  import tblacc_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  output logic              busy,
  output logic              done,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] tbl_ptr,
  output logic [DATA_W-1:0] tbl_latch,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic  acc_rd, acc_wr, capture, cfg_take;
  step_e ptr_step;

  tblacc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mode  (req_mode),
    .cfg_we    (cfg_we),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .capture   (capture),
    .cfg_take  (cfg_take),
    .ptr_step  (ptr_step)
  );

  tblacc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (cfg_take && (cfg_sel == CFG_SEL_PTR)),
    .load_val (cfg_wdata),
    .step     (ptr_step),
    .ptr_q    (tbl_ptr)
  );

  tblacc_latch #(.DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (cfg_take && (cfg_sel == CFG_SEL_LATCH)),
    .load_val (cfg_wdata[DATA_W-1:0]),
    .cap_en   (capture),
    .cap_val  (mem_rdata),
    .latch_q  (tbl_latch)
  );

  assign mem_addr  = tbl_ptr;
  assign mem_rd    = acc_rd;
  assign mem_wr    = acc_wr;
  assign mem_wdata = tbl_latch;

endmodule

// File: rtl/tblacc_chk.sv
`timescale 1ns/1ps
module tblacc_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_mode,
  input logic              busy,
  input logic              done,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic [ADDR_W-1:0] tbl_ptr,
  input logic [DATA_W-1:0] tbl_latch,
  input logic              mem_rd,
  input logic              mem_wr
);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R12
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && (mem_rd || mem_wr)));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  pre_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 2'd3) |=> (tbl_ptr == ($past(tbl_ptr) + ADDR_W'(1))));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> $stable(tbl_ptr));

  // R4
  write_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(tbl_latch));

  // R11
  cfg_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !busy && cfg_sel == 1'b0) |=> (tbl_ptr == $past(cfg_wdata)));

endmodule

bind tblacc_unit tblacc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mode  (req_mode),
  .busy      (busy),
  .done      (done),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .tbl_ptr   (tbl_ptr),
  .tbl_latch (tbl_latch),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr)
);

// File: tb/tb_tblacc_unit.sv
`timescale 1ns/1ps
module tb_tblacc_unit;
  localparam int AW = 21;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_mode = 2'd0;
  logic          req_ready, busy, done;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] tbl_ptr, mem_addr;
  logic [DW-1:0] tbl_latch, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rd, mem_wr;

  tblacc_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mode(req_mode), .busy(busy), .done(done),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tbl_ptr(tbl_ptr), .tbl_latch(tbl_latch), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    armed = 1'b0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  function automatic logic [7:0] seed_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'hA5;
  endfunction

  // synchronous program memory
  logic [7:0] bmem [int];
  always @(posedge clk) begin
    if (mem_wr) bmem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : seed_byte(mem_addr);
  end

  // behavioural reference
  int            phase;
  logic [AW-1:0] mptr;
  logic [DW-1:0] mlatch;
  logic          mwrite, mdone;
  logic [1:0]    mmode;
  logic [7:0]    mref [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; mptr = '0; mlatch = '0; mwrite = 1'b0; mdone = 1'b0; mmode = 2'd0;
    end else begin
      mdone = 1'b0;
      case (phase)
        0: begin
          if (cfg_we) begin
            if (cfg_sel) mlatch = cfg_wdata[7:0];
            else         mptr   = cfg_wdata;
          end else if (req_valid) begin
            mwrite = req_write; mmode = req_mode;
            if (req_mode == 2'd3) mptr = mptr + 1'b1;
            phase = 1;
          end
        end
        1: begin
          if (mwrite) mref[int'(mptr)] = mlatch;
          phase = 2;
        end
        default: begin
          if (!mwrite) mlatch = mref.exists(int'(mptr)) ? mref[int'(mptr)] : seed_byte(mptr);
          if (mmode == 2'd1)      mptr = mptr + 1'b1;
          else if (mmode == 2'd2) mptr = mptr - 1'b1;
          mdone = 1'b1;
          phase = 0;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && armed && !finished) begin
      chk("R2", "busy", 32'(busy), 32'(phase != 0));
      chk("R2", "req_ready", 32'(req_ready), 32'(phase == 0 && !cfg_we));
      chk("R2", "done", 32'(done), 32'(mdone));
      chk("R12", "mem_rd", 32'(mem_rd), 32'(phase == 1 && !mwrite));
      chk("R12", "mem_wr", 32'(mem_wr), 32'(phase == 1 && mwrite));
      if (phase == 1) chk(cur_req, "mem_addr", 32'(mem_addr), 32'(mptr));
      if (phase == 1 && mwrite) chk("R4", "mem_wdata", 32'(mem_wdata), 32'(mlatch));
      chk(cur_req, "tbl_ptr", 32'(tbl_ptr), 32'(mptr));
      chk(cur_req, "tbl_latch", 32'(tbl_latch), 32'(mlatch));
    end
  end

  task automatic do_cfg(input logic sel, input logic [AW-1:0] val);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic do_req(input logic w, input logic [1:0] m);
    @(posedge clk); #1 req_valid = 1'b1; req_write = w; req_mode = m;
    @(posedge clk); #1 req_valid = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tbl_ptr", 32'(tbl_ptr), 32'h0);
    chk("R1", "tbl_latch", 32'(tbl_latch), 32'h0);
    chk("R1", "busy", 32'(busy), 32'h0);
    chk("R1", "done", 32'(done), 32'h0);
    chk("R1", "req_ready", 32'(req_ready), 32'h1);
    chk("R1", "strobes", 32'({mem_rd, mem_wr}), 32'h0);
    armed = 1'b1;

    cur_req = "R11";
    do_cfg(1'b0, 21'h000100);
    do_cfg(1'b1, 21'h00003C);

    cur_req = "R4";  do_req(1'b1, 2'd0);
    cur_req = "R5";  do_req(1'b0, 2'd0);
    cur_req = "R3";
    do_cfg(1'b1, 21'h0000C7);
    do_req(1'b1, 2'd1);
    do_cfg(1'b0, 21'h000100);
    do_req(1'b0, 2'd1);
    do_req(1'b0, 2'd0);

    cur_req = "R6";
    for (int i = 0; i < 3; i++) do_req(1'b0, 2'd1);
    cur_req = "R7";
    do_req(1'b0, 2'd2); do_req(1'b0, 2'd2); do_req(1'b1, 2'd2);
    cur_req = "R8";
    do_req(1'b0, 2'd3); do_req(1'b0, 2'd3); do_req(1'b1, 2'd3);

    cur_req = "R9";
    do_cfg(1'b0, 21'h1FFFFF);
    do_req(1'b0, 2'd1);
    do_req(1'b0, 2'd2);
    do_req(1'b0, 2'd3);
    do_cfg(1'b0, 21'h000000);
    do_req(1'b0, 2'd2);
    do_cfg(1'b0, 21'h1FFFFE);
    do_req(1'b1, 2'd3);
    do_req(1'b0, 2'd1);

    cur_req = "R10";
    do_cfg(1'b0, 21'h000200);
    @(posedge clk); #1 req_valid = 1'b1; req_write = 1'b0; req_mode = 2'd1;
    @(posedge clk); #1 req_write = 1'b1; req_mode = 2'd2;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 21'h0ABCDE;
    @(posedge clk); #1 cfg_sel = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0; cfg_we = 1'b0;
    repeat (3) @(posedge clk);

    cur_req = "R2";
    @(posedge clk); #1 req_valid = 1'b1; req_write = 1'b0; req_mode = 2'd1;
    repeat (9) @(posedge clk);
    #1 req_valid = 1'b0;
    repeat (4) @(posedge clk);

    @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule